// File: doc/BRIEF.md
# Four-Pin Port Pad Controller

This block holds the software-visible settings of a four-pin general-purpose port and turns them into the per-pin control signals a pad ring needs: output enable, output level and pull-up enable. Four small registers sit on a byte-wide synchronous register bus: pin direction, output data, pull-up select and open-drain select. Reads are combinational from the address. Writes take effect on the clock edge when the write strobe is high.

The pad outputs are combinational functions of the registers and a 3-bit chip mode input, so a mode change acts at once, without any register write. Pull-up selects only act in modes 6 and 7. Open-drain selects only act in mode 7. An open-drain pin can only pull low: when its data bit is 1 it floats.

Hardware standby clears every register for as long as it is asserted. Software standby freezes the registers and ignores writes. The asynchronous active-low reset is released through a two-stage synchroniser. Until that release has passed through, the registers stay cleared and writes are dropped.

Top module: `gpio_pad_ctl`

## Requirements
- R1: While reset is asserted, and until it has been released through the synchroniser, all four registers read 0 and every pad output enable and pull-up enable is 0. A write made during reset is lost.
- R2: The registers are at addresses 0 (direction, 1 = output), 1 (output data), 2 (pull-up select) and 3 (open-drain select). A write stores wdata bits 3:0, one bit per pin with bit i for pin i. Read data returns the addressed register in bits 3:0. Bits 7:4 are reserved: writes to them are dropped and they read as 0.
- R3: While hardware standby is high, all four registers are cleared at each clock edge and writes are ignored.
- R4: While software standby is high and hardware standby is low, all four registers keep their contents and writes are ignored.
- R5: In modes 6 and 7, pad_pu[i] is 1 exactly when direction bit i is 0 and pull-up bit i is 1.
- R6: In modes 0 to 5, every pad_pu bit is 0 whatever the registers hold.
- R7: An output pin that is not open-drain-active has pad_oe[i] = 1 and pad_out[i] equal to data bit i.
- R8: In mode 7, an output pin with open-drain bit 1 has pad_out[i] = 0. Its pad_oe[i] is the inverse of data bit i.
- R9: In modes other than 7, the open-drain bits have no effect on pad_oe or pad_out.
- R10: An input pin (direction bit 0) has pad_oe[i] = 0. Its pad_out[i] equals data bit i.
- R11: The pad outputs follow a change of mode in the same cycle, with no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hw_stby | input | 1 | Hardware standby: clears the registers |
| sw_stby | input | 1 | Software standby: holds the registers |
| mode | input | 3 | Chip operating mode |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| pad_oe | output | 4 | Per-pin output enable |
| pad_out | output | 4 | Per-pin output level |
| pad_pu | output | 4 | Per-pin pull-up enable |

## Verification
Two things can fall in the same cycle: a register write and a standby request, or a register write and a reset.

The bench raises each standby input in the same cycle as a write strobe carrying a nonzero value. It then checks through readback that hardware standby wins and clears the register, and that software standby keeps the old value. It also pulls reset low while a write is on the bus and confirms the value never appears.

Mode changes are made between writes, so the pad outputs are judged against the reference model in the very cycle the mode moves.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int unsigned REG_COUNT = 4;
  localparam logic [1:0] A_DIR  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_PULL = 2'd2;
  localparam logic [1:0] A_OD   = 2'd3;
  localparam logic [2:0] MODE_PULL_LO = 3'd6;
  localparam logic [2:0] MODE_PULL_HI = 3'd7;
  localparam logic [2:0] MODE_OD      = 3'd7;
endpackage

// File: rtl/gpio_ctl_reg.sv
module gpio_ctl_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         hold,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = clr | (we & ~hold);
    q_nxt = clr ? '0 : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R3
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  // R4
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> $stable(q));
endmodule

// File: rtl/gpio_pad_logic.sv
module gpio_pad_logic
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic [NP-1:0] dir,
  input  logic [NP-1:0] dat,
  input  logic [NP-1:0] pul,
  input  logic [NP-1:0] odr,
  output logic [NP-1:0] pad_oe,
  output logic [NP-1:0] pad_out,
  output logic [NP-1:0] pad_pu
);
  logic pu_mode;
  logic od_mode;

  always_comb begin
    pu_mode = (mode == MODE_PULL_LO) || (mode == MODE_PULL_HI);
    od_mode = (mode == MODE_OD);
  end

  for (genvar i = 0; i < NP; i++) begin : g_pin
    logic od_act;
    always_comb begin
      od_act     = od_mode & odr[i] & dir[i];
      pad_pu[i]  = pu_mode & ~dir[i] & pul[i];
      pad_out[i] = dat[i] & ~od_act;
      pad_oe[i]  = dir[i] & ~(od_act & dat[i]);
    end
  end

  // R5
  pu_input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & dir) == '0));
  // R6
  pu_mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_PULL_LO && mode != MODE_PULL_HI) |-> (pad_pu == '0));
  // R8
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OD) |-> ((pad_oe & pad_out & odr) == '0));
  // R9
  od_mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_OD) |-> (pad_oe == dir));
  // R10
  input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~dir) == '0));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NP = 4,
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NP-1:0] pad_oe,
  output logic [NP-1:0] pad_out,
  output logic [NP-1:0] pad_pu
);
  localparam int unsigned PAD_W = DW - NP;

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [NP-1:0] reg_q [REG_COUNT];
  logic [NP-1:0] rd_sel;
  logic          unused_wdata_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n      = rst_pipe[1];
  assign unused_wdata_hi = ^wdata[DW-1:NP];

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
    gpio_ctl_reg #(.W(NP)) i_reg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (hw_stby),
      .hold  (sw_stby),
      .we    (wr_en && (addr == AW'(r))),
      .d     (wdata[NP-1:0]),
      .q     (reg_q[r])
    );
  end

  always_comb begin
    rd_sel = reg_q[addr];
    rdata  = {{PAD_W{1'b0}}, rd_sel};
  end

  gpio_pad_logic #(.NP(NP)) i_pads (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mode    (mode),
    .dir     (reg_q[A_DIR]),
    .dat     (reg_q[A_DATA]),
    .pul     (reg_q[A_PULL]),
    .odr     (reg_q[A_OD]),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .pad_pu  (pad_pu)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (pad_oe == '0 && pad_pu == '0));
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rdata[DW-1:NP] == '0));
endmodule

// File: tb/test_gpio_pad_ctl.sv
module test_gpio_pad_ctl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n, hw_stby, sw_stby, wr_en;
  logic [2:0] mode;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic [3:0] pad_oe, pad_out, pad_pu;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  logic [3:0] m_reg [4];
  int         m_sync;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pad_ctl i_gpio_pad_ctl (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .mode(mode), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  // Reference model: behavioural register state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) m_reg[k] <= 4'h0;
      m_sync <= 0;
    end else begin
      if (m_sync < 2) m_sync <= m_sync + 1;
      if (m_sync >= 2) begin
        if (hw_stby) for (int k = 0; k < 4; k++) m_reg[k] <= 4'h0;
        else if (wr_en && !sw_stby) m_reg[addr] <= wdata[3:0];
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [3:0] e_oe, e_out, e_pu;
    for (int i = 0; i < 4; i++) begin
      logic d, v, p, o;
      d = m_reg[0][i]; v = m_reg[1][i]; p = m_reg[2][i]; o = m_reg[3][i];
      e_pu[i] = (mode == 3'd6 || mode == 3'd7) && !d && p;
      if (!d) begin
        e_oe[i] = 1'b0; e_out[i] = v;
      end else if (mode == 3'd7 && o) begin
        e_oe[i] = !v; e_out[i] = 1'b0;
      end else begin
        e_oe[i] = 1'b1; e_out[i] = v;
      end
    end
    check(cur_req, "rdata", int'(rdata), int'({4'h0, m_reg[addr]}));
    check(cur_req, "pad_oe", int'(pad_oe), int'(e_oe));
    check(cur_req, "pad_out", int'(pad_out), int'(e_out));
    check(cur_req, "pad_pu", int'(pad_pu), int'(e_pu));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] v);
    addr = a; wdata = v; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, logic [1:0] a, logic [3:0] exp);
    addr = a;
    #1;
    check(req, "readback", int'(rdata), int'({4'h0, exp}));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0; wr_en = 1'b0;
    mode = 3'd7; addr = 2'd0; wdata = 8'h00;
    // R1: write during reset is lost
    @(negedge clk);
    addr = 2'd0; wdata = 8'hFF; wr_en = 1'b1;
    tick(); tick();
    wr_en = 1'b0;
    cur_req = "R1";
    for (int a = 0; a < 4; a++) rd_check("R1", 2'(a), 4'h0);
    check("R1", "pad_oe in reset", int'(pad_oe), 0);
    check("R1", "pad_pu in reset", int'(pad_pu), 0);
    rst_n = 1'b1;
    // R1: the synchroniser still holds the registers cleared
    wr(2'd1, 8'h0F);
    rd_check("R1", 2'd1, 4'h0);
    tick(); tick();

    // R2: store and read back; reserved bits dropped
    cur_req = "R2";
    wr(2'd0, 8'hF3); wr(2'd1, 8'hA5); wr(2'd2, 8'h7C); wr(2'd3, 8'h96);
    rd_check("R2", 2'd0, 4'h3); rd_check("R2", 2'd1, 4'h5);
    rd_check("R2", 2'd2, 4'hC); rd_check("R2", 2'd3, 4'h6);

    // R5 R6 R7 R9 R11: sweep every mode, no writes between
    wr(2'd0, 8'h05); wr(2'd1, 8'h03); wr(2'd2, 8'h0F); wr(2'd3, 8'h0F);
    for (int m = 0; m < 8; m++) begin
      cur_req = (m >= 6) ? "R5" : "R6";
      mode = 3'(m);
      #1;
      // R11: pads follow the new mode within the same cycle
      check("R11", "pad_pu mode change", int'(pad_pu), (m >= 6) ? 32'hA : 0);
      check("R9", "pad_oe vs od", int'(pad_oe), (m == 7) ? 32'h4 : 32'h5);
      tick();
    end

    // R7 R8 R10: open-drain patterns
    cur_req = "R8";
    mode = 3'd7;
    wr(2'd0, 8'h0F); wr(2'd3, 8'h0C);
    for (int v = 0; v < 16; v += 5) begin
      wr(2'd1, 8'(v));
      check("R8", "od oe", int'(pad_oe[3:2]), int'(~v[3:2]) & 3);
      check("R7", "pp out", int'(pad_out[1:0]), v & 3);
    end
    cur_req = "R10";
    wr(2'd0, 8'h00); wr(2'd1, 8'h0F);
    check("R10", "input oe", int'(pad_oe), 0);
    check("R10", "input out", int'(pad_out), 15);

    // R4: software standby retains, write in same cycle ignored
    cur_req = "R4";
    wr(2'd2, 8'h09);
    sw_stby = 1'b1;
    wr(2'd2, 8'h06);
    tick();
    rd_check("R4", 2'd2, 4'h9);
    sw_stby = 1'b0;

    // R3: hardware standby clears, write in same cycle ignored
    cur_req = "R3";
    hw_stby = 1'b1;
    wr(2'd3, 8'h0F);
    for (int a = 0; a < 4; a++) rd_check("R3", 2'(a), 4'h0);
    hw_stby = 1'b0;
    wr(2'd3, 8'h0A);
    rd_check("R3", 2'd3, 4'hA);

    // R3 R4: both standbys together, hardware wins
    sw_stby = 1'b1; hw_stby = 1'b1;
    tick();
    rd_check("R3", 2'd3, 4'h0);
    sw_stby = 1'b0; hw_stby = 1'b0;
    tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule